// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Atomic Bit Operations

A 32-pin general-purpose I/O port driven from a simple word-wide register bus. Software writes a full output word, or changes chosen pins without a read-modify-write. Writing ones to the set word raises those outputs, to the clear word lowers them, and to the flip word inverts them. A direction word turns each pin's output driver on or off. Pin levels arrive asynchronously, pass through a two-stage synchronizer, and are read back through a read-only sample word.

Every bus access to a mapped word finishes in the cycle it is presented. An access to any other offset is answered one cycle later with an error flag, and a write there changes nothing. Each pin is modelled as three separate signals: output level, output enable and input level. The reset input is asynchronous and active low, and its release is synchronized inside the block.

Top module: `gpio_port`

## Requirements
- R1: After reset the output word, the direction word, `pin_out` and `pin_oe` are all zero, and the pin sample word reads zero.
- R2: Offset 0x00 is the output word. A write replaces it, a read returns it, and `pin_out` shows it from the next clock edge.
- R3: Offset 0x04 is the set word. Each written 1 forces that output bit to 1, and each written 0 leaves that bit unchanged.
- R4: Offset 0x08 is the clear word. Each written 1 forces that output bit to 0, and each written 0 leaves that bit unchanged.
- R5: Offset 0x0C is the flip word. Each written 1 inverts that output bit, and each written 0 leaves that bit unchanged.
- R6: Reads of offsets 0x04, 0x08 and 0x0C always return zero.
- R7: Offset 0x10 is the pin sample word. A read returns `pin_in` as it was two clock edges earlier, and a write to it has no effect on any register.
- R8: Offset 0x14 is the direction word, readable and writable. `pin_oe` equals this word from the clock edge after the write, where 1 means the pin is driven.
- R9: An access to a mapped offset raises `bus_ready` in the same cycle as `bus_valid`, with `bus_err` low.
- R10: An access whose offset is not a multiple of 4, or is above 0x14, keeps `bus_ready` low for its first cycle and raises `bus_ready` together with `bus_err` for one cycle in the next. A write there changes no register.
- R11: `pin_out` and `pin_oe` change only at a clock edge that follows an accepted write to a word that affects them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request present; held until `bus_ready` |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access complete |
| bus_err | output | 1 | Access was to an unmapped offset (valid with `bus_ready`) |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` on a mapped read |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Registered output levels |
| pin_oe | output | 32 | Output enables |

## Verification
Two functions can act in the same cycle. An atomic set, clear or flip write can land in the cycle where a new pin level enters the synchronizer, and an error response's wait cycle can overlap a pin change. The bench changes `pin_in` at the same falling edge where it presents each request, including unmapped ones. A reference pipeline in the bench delays the pin levels by two edges. Every later read of the sample word is compared with that pipeline, and the output word is compared with a bench-side model of the set, clear and flip arithmetic.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned OFS_OUT   = 32'h00;
  localparam int unsigned OFS_SET   = 32'h04;
  localparam int unsigned OFS_CLR   = 32'h08;
  localparam int unsigned OFS_FLIP  = 32'h0C;
  localparam int unsigned OFS_SAMP  = 32'h10;
  localparam int unsigned OFS_DIR   = 32'h14;

  typedef enum logic [2:0] {
    SEL_OUT  = 3'd0,
    SEL_SET  = 3'd1,
    SEL_CLR  = 3'd2,
    SEL_FLIP = 3'd3,
    SEL_SAMP = 3'd4,
    SEL_DIR  = 3'd5,
    SEL_NONE = 3'd6
  } reg_sel_e;

endpackage

// File: rtl/gpio_port_rst_sync.sv
module gpio_port_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              hit
);

  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_W'(OFS_OUT))  sel = SEL_OUT;
    if (addr == ADDR_W'(OFS_SET))  sel = SEL_SET;
    if (addr == ADDR_W'(OFS_CLR))  sel = SEL_CLR;
    if (addr == ADDR_W'(OFS_FLIP)) sel = SEL_FLIP;
    if (addr == ADDR_W'(OFS_SAMP)) sel = SEL_SAMP;
    if (addr == ADDR_W'(OFS_DIR))  sel = SEL_DIR;
  end

  assign hit = (sel != SEL_NONE);

  // R10: a mapped hit is always word aligned and inside the window
  always_comb begin
    if (hit) begin
      a_r10_hit_in_window: assert ((addr[1:0] == 2'b00) && (addr <= ADDR_W'(OFS_DIR)));
    end
  end

endmodule

// File: rtl/gpio_port_bus_ctrl.sv
module gpio_port_bus_ctrl (
  input  logic clk,
  input  logic rst_ni,
  input  logic req_valid,
  input  logic req_hit,
  output logic rsp_ready,
  output logic rsp_err,
  output logic acc_fire
);

  logic err_wait_q;
  logic err_wait_d;

  always_comb begin
    err_wait_d = req_valid && !req_hit && !err_wait_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) err_wait_q <= 1'b0;
    else         err_wait_q <= err_wait_d;
  end

  assign acc_fire  = req_valid && req_hit;
  assign rsp_ready = acc_fire || err_wait_q;
  assign rsp_err   = err_wait_q;

  // R9: mapped access answered in its own cycle without error
  a_r9_zero_wait: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_hit) |-> (rsp_ready && !rsp_err));

  // R10: first cycle of an unmapped access is a wait
  a_r10_wait_first: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && !req_hit && !err_wait_q) |-> !rsp_ready);

  // R10: error response arrives exactly one cycle later
  a_r10_err_next: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && !req_hit && !err_wait_q) |=> (rsp_ready && rsp_err));

  // R10: error never outlasts one cycle
  a_r10_err_single: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_err |=> !rsp_err);

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] dir_q
);

  logic [WIDTH-1:0] out_d;
  logic [WIDTH-1:0] dir_d;
  logic             out_en;
  logic             dir_en;

  always_comb begin
    out_en = wr_en && ((wr_sel == SEL_OUT) || (wr_sel == SEL_SET) ||
                       (wr_sel == SEL_CLR) || (wr_sel == SEL_FLIP));
    dir_en = wr_en && (wr_sel == SEL_DIR);
  end

  always_comb begin
    out_d = out_q;
    dir_d = dir_q;
    unique case (wr_sel)
      SEL_OUT:  out_d = wdata;
      SEL_SET:  out_d = out_q | wdata;
      SEL_CLR:  out_d = out_q & ~wdata;
      SEL_FLIP: out_d = out_q ^ wdata;
      SEL_DIR:  dir_d = wdata;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     out_q <= '0;
    else if (out_en) out_q <= out_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  // R3: written ones become 1, others keep their value
  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_sel == SEL_SET) |=>
      (((out_q & $past(wdata)) == $past(wdata)) &&
       ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata)))));

  // R4: written ones become 0, others keep their value
  a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_sel == SEL_CLR) |=>
      (((out_q & $past(wdata)) == '0) &&
       ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata)))));

  // R5: written ones invert
  a_r5_flip_bits: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_sel == SEL_FLIP) |=> (out_q == ($past(out_q) ^ $past(wdata))));

  // R11: output word holds unless a write to it was accepted
  a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !(wr_en && (wr_sel inside {SEL_OUT, SEL_SET, SEL_CLR, SEL_FLIP})) |=> $stable(out_q));

  // R8: direction holds unless written
  a_r8_dir_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !(wr_en && wr_sel == SEL_DIR) |=> $stable(dir_q));

endmodule

// File: rtl/gpio_port_insync.sv
module gpio_port_insync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= async_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic              bus_ready,
  output logic              bus_err,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);

  logic             rst_ni;
  reg_sel_e         sel;
  logic             hit;
  logic             acc_fire;
  logic             wr_en;
  logic [WIDTH-1:0] out_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] samp;

  gpio_port_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ni)
  );

  gpio_port_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .hit  (hit)
  );

  gpio_port_bus_ctrl u_bus (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .req_valid (bus_valid),
    .req_hit   (hit),
    .rsp_ready (bus_ready),
    .rsp_err   (bus_err),
    .acc_fire  (acc_fire)
  );

  assign wr_en = acc_fire && bus_write;

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk    (clk),
    .rst_ni (rst_ni),
    .wr_en  (wr_en),
    .wr_sel (sel),
    .wdata  (bus_wdata),
    .out_q  (out_q),
    .dir_q  (dir_q)
  );

  gpio_port_insync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .async_in (pin_in),
    .sync_out (samp)
  );

  always_comb begin
    bus_rdata = '0;
    if (acc_fire && !bus_write) begin
      unique case (sel)
        SEL_OUT:  bus_rdata = out_q;
        SEL_SAMP: bus_rdata = samp;
        SEL_DIR:  bus_rdata = dir_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  // R6: write-only words read as zero
  a_r6_wo_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_valid && !bus_write && (sel inside {SEL_SET, SEL_CLR, SEL_FLIP})) |-> (bus_rdata == '0));

  // R11: pin enables move only after an accepted write
  a_r11_oe_stable: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_en |=> $stable(pin_oe));

endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;

  logic        clk;
  logic        rst_n;
  logic        bus_valid;
  logic        bus_write;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_ready;
  logic        bus_err;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  logic [31:0] exp_out = '0;
  logic [31:0] exp_dir = '0;
  logic [31:0] m1 = '0;
  logic [31:0] m2 = '0;
  bit          done = 0;

  gpio_port uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference two-edge delay of pin levels (R7)
  always @(posedge clk) begin
    if (!rst_n) begin
      m1 <= '0;
      m2 <= '0;
    end else begin
      m1 <= pin_in;
      m2 <= m1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_bad(input logic [7:0] a);
    return (a[1:0] != 2'b00) || (a > 8'h14);
  endfunction

  function automatic logic [31:0] next_out(input logic [7:0] a, input logic [31:0] cur,
                                            input logic [31:0] w);
    case (a)
      8'h00:   return w;
      8'h04:   return cur | w;
      8'h08:   return cur & ~w;
      8'h0C:   return cur ^ w;
      default: return cur;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00:   return exp_out;
      8'h10:   return m2;
      8'h14:   return exp_dir;
      default: return 32'h0;
    endcase
  endfunction

  // one bus access, with a pin change in the same cycle
  task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] w,
                        input logic [31:0] pins, input string tag);
    logic [31:0] er;
    @(negedge clk);
    bus_valid = 1'b1;
    bus_write = wr;
    bus_addr  = a;
    bus_wdata = w;
    pin_in    = pins;
    #1;
    if (is_bad(a)) begin
      check({tag, " R10 wait cycle ready"}, {31'b0, bus_ready}, 32'd0);
      @(negedge clk);
      #1;
      check({tag, " R10 error ready"}, {30'b0, bus_ready, bus_err}, 32'd3);
    end else begin
      check({tag, " R9 same-cycle ready"}, {30'b0, bus_ready, bus_err}, 32'd2);
      if (!wr) begin
        er = exp_read(a);
        check({tag, (a inside {8'h04, 8'h08, 8'h0C}) ? " R6 wo read zero" :
                    (a == 8'h10) ? " R7 sample read" :
                    (a == 8'h14) ? " R8 dir read" : " R2 out read"}, bus_rdata, er);
      end else begin
        exp_out = next_out(a, exp_out, w);
        if (a == 8'h14) exp_dir = w;
      end
    end
    @(negedge clk);
    bus_valid = 1'b0;
    bus_write = 1'b0;
    #1;
    check({tag, " R11 pin_out R3 R4 R5"}, pin_out, exp_out);
    check({tag, " R8 pin_oe"}, pin_oe, exp_dir);
  endtask

  initial begin
    void'($urandom(32'h5EED_2024));
    rst_n     = 1'b0;
    bus_valid = 1'b0;
    bus_write = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    pin_in    = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 pin_out reset", pin_out, 32'h0);
    check("R1 pin_oe reset", pin_oe, 32'h0);
    access(1'b0, 8'h00, 0, 0, "R1 out word");
    access(1'b0, 8'h14, 0, 0, "R1 dir word");
    access(1'b0, 8'h10, 0, 0, "R1 sample word");

    // directed corner cases
    access(1'b1, 8'h00, 32'hA5A5_0F0F, 32'h1234_5678, "R2 write");
    access(1'b0, 8'h00, 0, 32'h1234_5678, "R2 readback");
    access(1'b1, 8'h04, 32'h0000_0000, 32'h0, "R3 zero set");
    access(1'b1, 8'h04, 32'h5000_00F0, 32'h0, "R3 set");
    access(1'b1, 8'h08, 32'h0000_0000, 32'h0, "R4 zero clear");
    access(1'b1, 8'h08, 32'hFFFF_0000, 32'h0, "R4 clear");
    access(1'b1, 8'h0C, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 flip all");
    access(1'b0, 8'h04, 0, 32'hFFFF_FFFF, "R6 set read");
    access(1'b0, 8'h08, 0, 32'hFFFF_FFFF, "R6 clear read");
    access(1'b0, 8'h0C, 0, 32'hFFFF_FFFF, "R6 flip read");
    access(1'b1, 8'h10, 32'hDEAD_BEEF, 32'hFFFF_FFFF, "R7 write ignored");
    access(1'b0, 8'h10, 0, 32'h0, "R7 sample after hold");
    access(1'b1, 8'h14, 32'h00FF_00FF, 32'h0, "R8 dir write");
    access(1'b1, 8'h01, 32'hFFFF_FFFF, 32'h0, "R10 misaligned write");
    access(1'b1, 8'h18, 32'h0, 32'h0, "R10 above window write");
    access(1'b0, 8'hFC, 0, 32'h0, "R10 far read");
    access(1'b0, 8'h00, 0, 32'h0, "R10 out after bad writes");
    access(1'b0, 8'h14, 0, 32'h0, "R10 dir after bad writes");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      int unsigned pick;
      pick = $urandom_range(0, 9);
      if (pick < 8) a = 8'(($urandom_range(0, 5)) * 4);
      else          a = 8'($urandom);
      access(($urandom_range(0, 1) == 1), a, $urandom, $urandom, "RND");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule